// File: doc/BRIEF.md
# Host Address Decoder with System-Bus Window

This block classifies every access issued by a 16-bit host processor that has a 1 MB memory space and a 64 KB I/O space. Each memory access goes to one of three places: on-board DRAM, a window that reaches into a 32-bit system-bus address space, or a bank of four ROM sockets. Each I/O access goes either to local peripherals or out to bus I/O. For window hits and forwarded I/O, the block also forms the outgoing 32-bit bus address. All of this host-side decode is combinational from the address and the memory/I/O strobe.

A second, independent path looks at inbound system-bus memory accesses. It decides whether such an access lands in the dual-ported slice of local DRAM, and if so it gives the DRAM offset. A small write-only configuration port sets the window size, the window base, the ROM device size and the dual-port bounds. A write takes effect on the cycle after it is clocked in.

Top module: `hostmap_decoder`

## Requirements
- R1: A memory access with address below 0x80000 (512K) selects DRAM, which is target bit 0 of `tgt_sel`.
- R2: The window always starts at 0x80000. It ends at 0x9FFFF when the window-size register is 0 (128 KB) and at 0xBFFFF when it is 1 (256 KB). A hit selects target bit 1.
- R3: On a window hit, `bus_addr` is the window base with all bits below the window size forced to zero, plus (host address − 0x80000).
- R4: Memory addresses above the window belong to the ROM region (target bit 2). The ROM code selects the device size: 0=8K, 1=16K, 2=32K, 3=64K bytes. The four sockets sit at the top of the 1 MB space. The socket number is host address bits [s+1:s], and `rom_offset` is bits [s-1:0], where 2^s is the device size.
- R5: A ROM-region access below the top 4×device-size bytes raises `rom_unmapped` and selects no target.
- R6: An I/O access uses only address bits [15:0]. If bit 15 is 0, it selects local I/O (target bit 3). If bit 15 is 1, it selects bus I/O (target bit 4) with `bus_addr` equal to the zero-extended 16-bit address.
- R7: An inbound access hits (`in_hit`) only when the dual-port region is enabled, its 64 KB block number (bits [31:16]) lies from the start block to the end block inclusive, and it is less than 512K above the start. In that case `in_dram_addr` = in_addr − start×64K.
- R8: An inbound access that fails R7 raises `in_miss` instead of `in_hit`. Exactly one of the two is high while `in_valid` is high, and neither is high otherwise.
- R9: After reset the configuration is a 128 KB window, base 0, ROM code 3 (64K) and the dual-port region disabled.
- R10: Configuration writes are selected by `cfg_sel`: 0 window size (bit 0), 1 window base (32 bits), 2 ROM code (bits 1:0), 3 dual-port start block (bits 15:0), 4 dual-port end block (bits 15:0), 5 dual-port enable (bit 0). The new value applies from the next cycle.
- R11: `tgt_sel` is zero or one-hot, and it is zero when `host_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| host_req | input | 1 | Host access valid |
| host_io | input | 1 | 1 = I/O access, 0 = memory access |
| host_addr | input | 20 | Host address |
| tgt_sel | output | 5 | One-hot target: DRAM, window, ROM, local I/O, bus I/O |
| bus_addr | output | 32 | System-bus address for window or bus I/O, else 0 |
| rom_socket | output | 2 | Selected ROM socket |
| rom_offset | output | 16 | Byte offset inside the selected ROM device |
| rom_unmapped | output | 1 | ROM-region access outside the installed sockets |
| in_valid | input | 1 | Inbound bus memory access valid |
| in_addr | input | 32 | Inbound bus address |
| in_hit | output | 1 | Inbound access hits dual-port DRAM |
| in_miss | output | 1 | Inbound access misses |
| in_dram_addr | output | 19 | DRAM offset for an inbound hit |

## Verification
The bench probes both edges of the window under each size. A wrong end address would send 0xA0000 to the bus when the window is 128 KB, or to ROM when it is 256 KB. It uses a window base whose bit 17 is set, so a decoder that forgets to clear the base bits for the larger window gives a bus address off by 128K. The bench walks the ROM through all four device sizes, testing the first socket, a middle socket, the last byte and the byte just below the socket bank. A wrong bit slice shows up as a wrong socket, and a missing capacity test shows up as a false ROM select. On the inbound side it hits both bound blocks and the blocks just outside them. It also tests a region wider than DRAM, where an access 512K above the start must miss rather than wrap around into DRAM, and the disabled state.

// File: rtl/hmd_pkg.sv
// Shared constants for the host address decoder: target bit positions
// and configuration register select codes.
package hmd_pkg;
    localparam int N_TGT  = 5;
    localparam int T_DRAM = 0;
    localparam int T_WIN  = 1;
    localparam int T_ROM  = 2;
    localparam int T_LIO  = 3;
    localparam int T_BIO  = 4;

    localparam int SEL_W = 3;
    localparam logic [SEL_W-1:0] SEL_WSIZE = 3'd0;
    localparam logic [SEL_W-1:0] SEL_WBASE = 3'd1;
    localparam logic [SEL_W-1:0] SEL_ROM   = 3'd2;
    localparam logic [SEL_W-1:0] SEL_DPLO  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_DPHI  = 3'd4;
    localparam logic [SEL_W-1:0] SEL_DPEN  = 3'd5;
endpackage

// File: rtl/hmd_cfg_regs.sv
// Configuration register file. It holds the window size, the window base,
// the ROM size code and the dual-port bounds and enable.
// Assumes one write per cycle. Each write is visible from the next cycle.
module hmd_cfg_regs
    import hmd_pkg::*;
#(
    parameter int BUS_AW  = 32,
    parameter int GRAN_AW = 16,
    parameter int CODE_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [SEL_W-1:0]          cfg_sel,
    input  logic [BUS_AW-1:0]         cfg_wdata,
    output logic                      win_large,
    output logic [BUS_AW-1:0]         win_base,
    output logic [CODE_W-1:0]         rom_code,
    output logic                      dp_en,
    output logic [BUS_AW-GRAN_AW-1:0] dp_lo,
    output logic [BUS_AW-GRAN_AW-1:0] dp_hi
);
    localparam int BLK_W = BUS_AW - GRAN_AW;

    // Register update: reset defaults, then one selected field per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_large <= 1'b0;
            win_base  <= '0;
            rom_code  <= '1;
            dp_en     <= 1'b0;
            dp_lo     <= '0;
            dp_hi     <= '0;
        end else if (cfg_we) begin
            case (cfg_sel)
                SEL_WSIZE: win_large <= cfg_wdata[0];
                SEL_WBASE: win_base  <= cfg_wdata;
                SEL_ROM:   rom_code  <= cfg_wdata[CODE_W-1:0];
                SEL_DPLO:  dp_lo     <= cfg_wdata[BLK_W-1:0];
                SEL_DPHI:  dp_hi     <= cfg_wdata[BLK_W-1:0];
                SEL_DPEN:  dp_en     <= cfg_wdata[0];
                default: ;
            endcase
        end
    end

    p_base_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_we) && $past(cfg_sel) == SEL_WBASE)
            |-> win_base == $past(cfg_wdata));

    p_code_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_we) && $past(cfg_sel) == SEL_ROM)
            |-> rom_code == $past(cfg_wdata[CODE_W-1:0]));

    p_defaults_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!win_large && win_base == '0 && rom_code == '1 && !dp_en));
endmodule

// File: rtl/hmd_mem_dec.sv
// Memory region split for host addresses: DRAM, then the bus window, then
// the ROM region. It also forms the bus address for a window hit.
// Assumes the window begins right above DRAM and that both window sizes
// end below the top of the host space.
module hmd_mem_dec #(
    parameter int HOST_AW = 20,
    parameter int BUS_AW  = 32,
    parameter int DRAM_AW = 19,
    parameter int WIN_AW  = 17
) (
    input  logic [HOST_AW-1:0] addr,
    input  logic               win_large,
    input  logic [BUS_AW-1:0]  win_base,
    output logic               is_dram,
    output logic               is_win,
    output logic               is_romreg,
    output logic [BUS_AW-1:0]  win_bus
);
    localparam logic [HOST_AW-1:0] WIN_LO   = HOST_AW'(1 << DRAM_AW);
    localparam logic [HOST_AW-1:0] WIN_HI_S = HOST_AW'((1 << DRAM_AW) + (1 << WIN_AW));
    localparam logic [HOST_AW-1:0] WIN_HI_L = HOST_AW'((1 << DRAM_AW) + (2 << WIN_AW));
    localparam logic [BUS_AW-1:0]  MASK_S   = ~BUS_AW'((1 << WIN_AW) - 1);
    localparam logic [BUS_AW-1:0]  MASK_L   = ~BUS_AW'((2 << WIN_AW) - 1);

    logic [HOST_AW-1:0] win_hi;
    logic [HOST_AW-1:0] win_off;

    // Region compare against the window end chosen by the size setting.
    always_comb begin
        win_hi    = win_large ? WIN_HI_L : WIN_HI_S;
        is_dram   = addr < WIN_LO;
        is_win    = !is_dram && (addr < win_hi);
        is_romreg = !is_dram && !is_win;
    end

    // Bus address: aligned base plus the offset inside the window.
    always_comb begin
        win_off = addr - WIN_LO;
        win_bus = (win_base & (win_large ? MASK_L : MASK_S)) + BUS_AW'(win_off);
    end
endmodule

// File: rtl/hmd_rom_sel.sv
// ROM socket select. The socket bank is aligned to the top of the host
// space. One candidate decode is built per device size, and the size code
// picks among them. Assumes the socket count is a power of two and that
// the bank at its largest size fits below the top of the space.
module hmd_rom_sel #(
    parameter int HOST_AW    = 20,
    parameter int ROM_MIN_AW = 13,
    parameter int NSOCK      = 4,
    parameter int NCODE      = 4,
    parameter int CODE_W     = 2,
    parameter int SOCK_W     = 2,
    parameter int OFF_W      = 16
) (
    input  logic [HOST_AW-1:0] addr,
    input  logic [CODE_W-1:0]  code,
    output logic               mapped,
    output logic [SOCK_W-1:0]  socket,
    output logic [OFF_W-1:0]   offset
);
    logic [NCODE-1:0]  map_v;
    logic [SOCK_W-1:0] sock_v [NCODE];
    logic [OFF_W-1:0]  off_v  [NCODE];

    // One decode per device size: top bits all ones means inside the bank.
    for (genvar g = 0; g < NCODE; g++) begin : g_size
        localparam int DEV_AW  = ROM_MIN_AW + g;
        localparam int SPAN_AW = DEV_AW + SOCK_W;
        assign map_v[g]  = &addr[HOST_AW-1:SPAN_AW];
        assign sock_v[g] = addr[SPAN_AW-1:DEV_AW];
        assign off_v[g]  = OFF_W'(addr[DEV_AW-1:0]);
    end

    // Pick the candidate for the configured device size.
    always_comb begin
        mapped = map_v[code];
        socket = sock_v[code];
        offset = off_v[code];
    end
endmodule

// File: rtl/hmd_dp_dec.sv
// Inbound dual-port check. A bus access hits local DRAM when the region is
// enabled, the access block is inside [start, end], and the access is less
// than the DRAM size above the start. Assumes start <= end when enabled.
module hmd_dp_dec #(
    parameter int BUS_AW  = 32,
    parameter int DRAM_AW = 19,
    parameter int GRAN_AW = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [BUS_AW-1:0]         in_addr,
    input  logic                      dp_en,
    input  logic [BUS_AW-GRAN_AW-1:0] dp_lo,
    input  logic [BUS_AW-GRAN_AW-1:0] dp_hi,
    output logic                      in_hit,
    output logic                      in_miss,
    output logic [DRAM_AW-1:0]        in_dram_addr
);
    localparam int BLK_W   = BUS_AW - GRAN_AW;
    localparam int DBLK_AW = DRAM_AW - GRAN_AW;
    localparam logic [BLK_W-1:0] DRAM_BLKS = BLK_W'(1 << DBLK_AW);

    logic [BLK_W-1:0] blk;
    logic [BLK_W-1:0] rel;
    logic             in_bounds;

    // Bounds test and DRAM offset from the block index relative to start.
    always_comb begin
        blk          = in_addr[BUS_AW-1:GRAN_AW];
        rel          = blk - dp_lo;
        in_bounds    = dp_en && (blk >= dp_lo) && (blk <= dp_hi) && (rel < DRAM_BLKS);
        in_hit       = in_valid && in_bounds;
        in_miss      = in_valid && !in_bounds;
        in_dram_addr = {rel[DBLK_AW-1:0], in_addr[GRAN_AW-1:0]};
    end

    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_hit && in_miss));

    p_answer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (in_hit || in_miss));

    p_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_hit |-> (dp_en && in_valid));
endmodule

// File: rtl/hostmap_decoder.sv
// Top of the host address decoder. It routes each host access to DRAM, the
// bus window, ROM, local I/O or bus I/O, and checks inbound bus accesses
// against the dual-port region. The decode is combinational. Only the
// configuration is registered.
module hostmap_decoder
    import hmd_pkg::*;
#(
    parameter int HOST_AW    = 20,
    parameter int BUS_AW     = 32,
    parameter int IO_AW      = 16,
    parameter int DRAM_AW    = 19,
    parameter int WIN_AW     = 17,
    parameter int GRAN_AW    = 16,
    parameter int ROM_MIN_AW = 13,
    parameter int NSOCK      = 4,
    parameter int NCODE      = 4,
    localparam int SOCK_W    = $clog2(NSOCK),
    localparam int CODE_W    = $clog2(NCODE),
    localparam int OFF_W     = ROM_MIN_AW + NCODE - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [BUS_AW-1:0]  cfg_wdata,
    input  logic               host_req,
    input  logic               host_io,
    input  logic [HOST_AW-1:0] host_addr,
    output logic [N_TGT-1:0]   tgt_sel,
    output logic [BUS_AW-1:0]  bus_addr,
    output logic [SOCK_W-1:0]  rom_socket,
    output logic [OFF_W-1:0]   rom_offset,
    output logic               rom_unmapped,
    input  logic               in_valid,
    input  logic [BUS_AW-1:0]  in_addr,
    output logic               in_hit,
    output logic               in_miss,
    output logic [DRAM_AW-1:0] in_dram_addr
);
    localparam int BLK_W = BUS_AW - GRAN_AW;

    logic               win_large;
    logic [BUS_AW-1:0]  win_base;
    logic [CODE_W-1:0]  rom_code;
    logic               dp_en;
    logic [BLK_W-1:0]   dp_lo;
    logic [BLK_W-1:0]   dp_hi;
    logic               is_dram, is_win, is_romreg;
    logic [BUS_AW-1:0]  win_bus;
    logic               rom_map;
    logic [SOCK_W-1:0]  rom_sock_raw;
    logic [OFF_W-1:0]   rom_off_raw;

    hmd_cfg_regs #(.BUS_AW(BUS_AW), .GRAN_AW(GRAN_AW), .CODE_W(CODE_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .win_large(win_large), .win_base(win_base),
        .rom_code(rom_code), .dp_en(dp_en), .dp_lo(dp_lo), .dp_hi(dp_hi)
    );

    hmd_mem_dec #(.HOST_AW(HOST_AW), .BUS_AW(BUS_AW), .DRAM_AW(DRAM_AW),
                  .WIN_AW(WIN_AW)) u_mem (
        .addr(host_addr), .win_large(win_large), .win_base(win_base),
        .is_dram(is_dram), .is_win(is_win), .is_romreg(is_romreg),
        .win_bus(win_bus)
    );

    hmd_rom_sel #(.HOST_AW(HOST_AW), .ROM_MIN_AW(ROM_MIN_AW), .NSOCK(NSOCK),
                  .NCODE(NCODE), .CODE_W(CODE_W), .SOCK_W(SOCK_W),
                  .OFF_W(OFF_W)) u_rom (
        .addr(host_addr), .code(rom_code), .mapped(rom_map),
        .socket(rom_sock_raw), .offset(rom_off_raw)
    );

    hmd_dp_dec #(.BUS_AW(BUS_AW), .DRAM_AW(DRAM_AW), .GRAN_AW(GRAN_AW)) u_dp (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .dp_en(dp_en), .dp_lo(dp_lo), .dp_hi(dp_hi), .in_hit(in_hit),
        .in_miss(in_miss), .in_dram_addr(in_dram_addr)
    );

    // Target choice and outgoing address for the current host access.
    always_comb begin
        tgt_sel      = '0;
        bus_addr     = '0;
        rom_unmapped = 1'b0;
        rom_socket   = '0;
        rom_offset   = '0;
        if (host_req) begin
            if (host_io) begin
                if (host_addr[IO_AW-1]) begin
                    tgt_sel[T_BIO] = 1'b1;
                    bus_addr       = BUS_AW'(host_addr[IO_AW-1:0]);
                end else begin
                    tgt_sel[T_LIO] = 1'b1;
                end
            end else if (is_dram) begin
                tgt_sel[T_DRAM] = 1'b1;
            end else if (is_win) begin
                tgt_sel[T_WIN] = 1'b1;
                bus_addr       = win_bus;
            end else if (is_romreg && rom_map) begin
                tgt_sel[T_ROM] = 1'b1;
                rom_socket     = rom_sock_raw;
                rom_offset     = rom_off_raw;
            end else begin
                rom_unmapped = 1'b1;
            end
        end
    end

    p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_sel));

    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !host_req |-> (tgt_sel == '0 && !rom_unmapped));

    p_io_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_io && host_addr[IO_AW-1])
            |-> (tgt_sel[T_BIO] && bus_addr == BUS_AW'(host_addr[IO_AW-1:0])));

    p_unmap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rom_unmapped |-> (tgt_sel == '0 && !host_io));

    p_dram_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_io && host_addr < HOST_AW'(1 << DRAM_AW))
            |-> tgt_sel[T_DRAM]);
endmodule

// File: tb/hostmap_decoder_bench.sv
// Scoreboard bench: driver tasks push expected results, a monitor pops and
// compares them one step after the stimulus settles.
module hostmap_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        host_req = 1'b0;
    logic        host_io = 1'b0;
    logic [19:0] host_addr = '0;
    logic [4:0]  tgt_sel;
    logic [31:0] bus_addr;
    logic [1:0]  rom_socket;
    logic [15:0] rom_offset;
    logic        rom_unmapped;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic        in_hit, in_miss;
    logic [18:0] in_dram_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        bit          inbound;
        logic [4:0]  tgt;
        logic [31:0] bus;
        logic [1:0]  sock;
        logic [15:0] off;
        logic        unm;
        logic        hit;
        logic        miss;
        logic [18:0] daddr;
        string       tag;
    } item_t;
    item_t q[$];

    always #2 clk = ~clk;

    hostmap_decoder u_hostmap_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .host_req(host_req), .host_io(host_io),
        .host_addr(host_addr), .tgt_sel(tgt_sel), .bus_addr(bus_addr),
        .rom_socket(rom_socket), .rom_offset(rom_offset),
        .rom_unmapped(rom_unmapped), .in_valid(in_valid), .in_addr(in_addr),
        .in_hit(in_hit), .in_miss(in_miss), .in_dram_addr(in_dram_addr)
    );

    task automatic cfg_write(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic host_chk(input logic req, input logic io, input logic [19:0] a,
                            input logic [4:0] t, input logic [31:0] b,
                            input logic [1:0] s, input logic [15:0] o,
                            input logic u, input string tag);
        item_t it;
        @(negedge clk);
        host_req = req; host_io = io; host_addr = a; in_valid = 1'b0;
        it.inbound = 1'b0; it.tgt = t; it.bus = b; it.sock = s; it.off = o;
        it.unm = u; it.hit = 1'b0; it.miss = 1'b0; it.daddr = '0; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic in_chk(input logic [31:0] a, input logic h,
                          input logic [18:0] d, input string tag);
        item_t it;
        @(negedge clk);
        host_req = 1'b0; in_valid = 1'b1; in_addr = a;
        it.inbound = 1'b1; it.tgt = '0; it.bus = '0; it.sock = '0; it.off = '0;
        it.unm = 1'b0; it.hit = h; it.miss = !h; it.daddr = d; it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: compare every pending item shortly after the stimulus edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t e;
                bit bad;
                e = q.pop_front();
                n_chk++;
                bad = 1'b0;
                if (e.inbound) begin
                    if (in_hit !== e.hit || in_miss !== e.miss) bad = 1'b1;
                    if (e.hit && in_dram_addr !== e.daddr) bad = 1'b1;
                    if (bad) begin
                        n_fail++;
                        $display("FAIL %s: hit=%b miss=%b dram=%h expected hit=%b miss=%b dram=%h",
                                 e.tag, in_hit, in_miss, in_dram_addr, e.hit, e.miss, e.daddr);
                    end
                end else begin
                    if (tgt_sel !== e.tgt || rom_unmapped !== e.unm) bad = 1'b1;
                    if ((e.tgt[1] || e.tgt[4]) && bus_addr !== e.bus) bad = 1'b1;
                    if (e.tgt[2] && (rom_socket !== e.sock || rom_offset !== e.off)) bad = 1'b1;
                    if (bad) begin
                        n_fail++;
                        $display("FAIL %s: tgt=%b bus=%h sock=%0d off=%h unm=%b expected tgt=%b bus=%h sock=%0d off=%h unm=%b",
                                 e.tag, tgt_sel, bus_addr, rom_socket, rom_offset, rom_unmapped,
                                 e.tgt, e.bus, e.sock, e.off, e.unm);
                    end
                end
            end
        end
    end

    // Watchdog: an expired run counts as one failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 R11: idle after reset selects nothing
        host_chk(1'b0, 1'b0, 20'h00000, 5'b00000, '0, '0, '0, 1'b0, "R11 idle");
        host_chk(1'b0, 1'b0, 20'hC0000, 5'b00000, '0, '0, '0, 1'b0, "R11 idle rom addr");
        // R1 DRAM edges
        host_chk(1'b1, 1'b0, 20'h00000, 5'b00001, '0, '0, '0, 1'b0, "R1 low");
        host_chk(1'b1, 1'b0, 20'h7FFFF, 5'b00001, '0, '0, '0, 1'b0, "R1 top");
        // R2 R3 R9 default 128K window, base 0
        host_chk(1'b1, 1'b0, 20'h80000, 5'b00010, 32'h0, '0, '0, 1'b0, "R2 R9 win start");
        host_chk(1'b1, 1'b0, 20'h9FFFF, 5'b00010, 32'h1FFFF, '0, '0, 1'b0, "R3 R9 win end");
        // R5 R9 default 64K ROM: 0xA0000..0xBFFFF is unmapped
        host_chk(1'b1, 1'b0, 20'hA0000, 5'b00000, '0, '0, '0, 1'b1, "R5 R9 past window");
        host_chk(1'b1, 1'b0, 20'hBFFFF, 5'b00000, '0, '0, '0, 1'b1, "R5 below bank");
        host_chk(1'b1, 1'b0, 20'hC0000, 5'b00100, '0, 2'd0, 16'h0000, 1'b0, "R4 R9 sock0");
        host_chk(1'b1, 1'b0, 20'hFFFFF, 5'b00100, '0, 2'd3, 16'hFFFF, 1'b0, "R4 sock3");
        // R6 I/O split
        host_chk(1'b1, 1'b1, 20'h00123, 5'b01000, '0, '0, '0, 1'b0, "R6 local io");
        host_chk(1'b1, 1'b1, 20'h07FFF, 5'b01000, '0, '0, '0, 1'b0, "R6 local io top");
        host_chk(1'b1, 1'b1, 20'hF8001, 5'b10000, 32'h8001, '0, '0, 1'b0, "R6 bus io");
        host_chk(1'b1, 1'b1, 20'h0FFFF, 5'b10000, 32'hFFFF, '0, '0, 1'b0, "R6 bus io top");
        // R8 R9 dual-port disabled after reset
        in_chk(32'h0000_0000, 1'b0, '0, "R8 R9 disabled");
        // R10 R3 base write with low bits forced zero, 128K
        cfg_write(3'd1, 32'h1236_5678);
        host_chk(1'b1, 1'b0, 20'h80010, 5'b00010, 32'h1236_0010, '0, '0, 1'b0, "R10 R3 base 128K");
        // R2 R3 256K window
        cfg_write(3'd0, 32'h1);
        host_chk(1'b1, 1'b0, 20'h80000, 5'b00010, 32'h1234_0000, '0, '0, 1'b0, "R3 base 256K");
        host_chk(1'b1, 1'b0, 20'hA0000, 5'b00010, 32'h1236_0000, '0, '0, 1'b0, "R2 256K mid");
        host_chk(1'b1, 1'b0, 20'hBFFFF, 5'b00010, 32'h1237_FFFF, '0, '0, 1'b0, "R2 256K end");
        host_chk(1'b1, 1'b0, 20'hC0000, 5'b00100, '0, 2'd0, 16'h0000, 1'b0, "R2 R4 rom after 256K");
        // R4 R5 8K devices: bank 0xF8000..0xFFFFF
        cfg_write(3'd2, 32'h0);
        host_chk(1'b1, 1'b0, 20'hF8000, 5'b00100, '0, 2'd0, 16'h0000, 1'b0, "R4 8K sock0");
        host_chk(1'b1, 1'b0, 20'hFA345, 5'b00100, '0, 2'd1, 16'h0345, 1'b0, "R4 8K sock1");
        host_chk(1'b1, 1'b0, 20'hFFFFF, 5'b00100, '0, 2'd3, 16'h1FFF, 1'b0, "R4 8K last");
        host_chk(1'b1, 1'b0, 20'hF7FFF, 5'b00000, '0, '0, '0, 1'b1, "R5 8K below");
        // 16K devices: bank 0xF0000..0xFFFFF
        cfg_write(3'd2, 32'h1);
        host_chk(1'b1, 1'b0, 20'hF4000, 5'b00100, '0, 2'd1, 16'h0000, 1'b0, "R4 16K sock1");
        host_chk(1'b1, 1'b0, 20'hEFFFF, 5'b00000, '0, '0, '0, 1'b1, "R5 16K below");
        // 32K devices: bank 0xE0000..0xFFFFF
        cfg_write(3'd2, 32'h2);
        host_chk(1'b1, 1'b0, 20'hE0000, 5'b00100, '0, 2'd0, 16'h0000, 1'b0, "R4 32K sock0");
        host_chk(1'b1, 1'b0, 20'hF9ABC, 5'b00100, '0, 2'd3, 16'h1ABC, 1'b0, "R4 32K sock3");
        host_chk(1'b1, 1'b0, 20'hDFFFF, 5'b00000, '0, '0, '0, 1'b1, "R5 32K below");
        // R7 R8 dual-port blocks 0x10..0x13
        cfg_write(3'd3, 32'h0010);
        cfg_write(3'd4, 32'h0013);
        in_chk(32'h0010_0000, 1'b0, '0, "R10 R8 still disabled");
        cfg_write(3'd5, 32'h1);
        in_chk(32'h0010_0000, 1'b1, 19'h00000, "R7 start");
        in_chk(32'h0013_FFFF, 1'b1, 19'h3FFFF, "R7 end");
        in_chk(32'h0014_0000, 1'b0, '0, "R8 above end");
        in_chk(32'h000F_FFFF, 1'b0, '0, "R8 below start");
        // R7 R8 region wider than DRAM
        cfg_write(3'd4, 32'h0020);
        in_chk(32'h0017_FFFF, 1'b1, 19'h7FFFF, "R7 dram top");
        in_chk(32'h0018_0000, 1'b0, '0, "R8 beyond dram");
        cfg_write(3'd5, 32'h0);
        in_chk(32'h0011_0000, 1'b0, '0, "R8 disabled again");
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule